// File: doc/BRIEF.md
# Turbo Decoder Half-Iteration Scheduler

This block controls one soft-in soft-out (SISO) engine that is shared by both constituent codes of a duo-binary turbo decoder. The two codes take turns, one half-iteration each. The block owns the extrinsic memory and the permutation table. For every half-iteration it produces the extrinsic read and write addresses, in natural order or through the permutation. It launches the engine with a one-cycle pulse and waits for the engine's one-cycle completion pulse, however long that takes. It also counts full iterations up to a programmed limit.

Every decode opens with the permuted-order pass, and every full iteration closes with the natural-order pass. Because of this order, the hard decisions of the last pass already come out in natural order and need no final deinterleave. During that pass the block raises a flag so the engine knows to emit its decisions. One cycle after that pass ends, the block pulses a completion output.

Memory is indexed by natural symbol position. The natural pass uses position k for its k-th access. The permuted pass uses entry k of the table. As a result, values written by one pass are read in the other pass's order.

Top module: `turbo_iter_sched`

## Requirements
- R1: After reset the block is idle. `busy_o`, `done_o`, `siso_start_o`, `siso_final_o` and `siso_half_o` are 0, and `ext_rdata_o` is 0. The permutation table holds the identity, and every extrinsic word is 0.
- R2: A start request accepted in idle gives a one-cycle `siso_start_o` pulse in the next cycle. A `siso_done_i` seen while waiting on the engine ends the half-iteration, and when more passes remain the next `siso_start_o` follows in the next cycle. Any number of cycles may pass between `siso_start_o` and `siso_done_i`. A `siso_done_i` that arrives outside the waiting state is ignored.
- R3: `siso_half_o` gives the pass order: 0 means permuted order and 1 means natural order. Separate read and write indices count accepted requests from 0 and wrap after N_SYM-1. Both indices clear on each launch. The physical address is the index itself when `siso_half_o`=1, and table entry [index] when `siso_half_o`=0.
- R4: The first pass of a decode is permuted order, and the passes then alternate. A full iteration is one permuted pass followed by one natural pass. The iteration count is `iter_limit_i` clamped to the range 1..MAX_ITER: 0 runs one iteration, and values above MAX_ITER run MAX_ITER iterations. A decode therefore launches 2×count passes.
- R5: A read returns data on `ext_rdata_o` one cycle after it is accepted. Reads in the first pass of a decode return 0. Later reads return the stored word. A read and a write in the same cycle to the same address return the old word. `ext_rdata_o` holds its value when no read is accepted.
- R6: `siso_final_o` is high throughout the last natural pass. `done_o` is a one-cycle pulse in the cycle after `siso_done_i` ends that pass.
- R7: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. A start request while busy is ignored, and so is its `iter_limit_i`.
- R8: A permutation write (`perm_we_i`, `perm_waddr_i`, `perm_wdata_i`) takes effect only while idle. Permutation writes while busy are ignored.
- R9: Extrinsic reads and writes are accepted only while waiting on the engine. Requests in the idle, launch or completion cycles neither move the indices nor touch the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| perm_we_i | input | 1 | Permutation table write enable |
| perm_waddr_i | input | AW | Table entry to write |
| perm_wdata_i | input | AW | Permuted position for that entry |
| start_i | input | 1 | Decode start request |
| iter_limit_i | input | IW | Requested number of full iterations |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | One-cycle pulse: decisions complete in natural order |
| siso_start_o | output | 1 | One-cycle engine launch pulse |
| siso_done_i | input | 1 | One-cycle engine completion pulse |
| siso_half_o | output | 1 | Pass order: 0 permuted, 1 natural |
| siso_final_o | output | 1 | Current pass is the final natural pass |
| ext_rd_en_i | input | 1 | Extrinsic read request |
| ext_rd_addr_o | output | AW | Physical address of the current read index |
| ext_rdata_o | output | EXT_W | Extrinsic read data, one cycle after the request |
| ext_wr_en_i | input | 1 | Extrinsic write request |
| ext_wdata_i | input | EXT_W | Extrinsic write data |
| ext_wr_addr_o | output | AW | Physical address of the current write index |

## Verification
The engine is emulated with several patterns:
- A dense pattern issues a read and a write every cycle. This exposes same-cycle read-before-write, and it shows whether values written by the permuted pass come back in natural positions.
- A sparse pattern has gaps and a long completion delay. This separates index advance on accepted requests from advance per cycle, and it checks latency tolerance.
- Some requests and stray completions are driven during the launch cycle, to show they are ignored.

Iteration limits of 0, 2, 3 and above the maximum check the clamp and the pass count. A start and a table write issued mid-decode must leave the run and later addresses unchanged.

// File: rtl/itsched_pkg.sv
package itsched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FIN    = 2'd3
  } sched_st_e;

  // Requested iteration count forced into 1..maxv.
  function automatic int clamp_limit(int req, int maxv);
    if (req < 1) return 1;
    if (req > maxv) return maxv;
    return req;
  endfunction

  // Symbol index advance with wrap at n.
  function automatic int next_idx(int idx, int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Physical address: natural pass uses the index, permuted pass the table.
  function automatic int map_addr(int idx, int perm_entry, logic natural);
    return natural ? idx : perm_entry;
  endfunction

endpackage

// File: rtl/itsched_ctrl.sv
module itsched_ctrl #(
  parameter int MAX_ITER = 8,
  parameter int IW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [IW-1:0] iter_limit_i,
  input  logic          siso_done_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          siso_start_o,
  output logic          half_o,
  output logic          final_o,
  output logic          active_o,
  output logic          first_pass_o
);
  import itsched_pkg::*;

  sched_st_e     st_q;
  logic          half_q;
  logic [IW-1:0] iter_q;
  logic [IW-1:0] lim_q;

  // Named internal events
  logic start_accept, start_ignored, half_done, last_pass;

  assign start_accept  = (st_q == ST_IDLE) && start_i;
  assign start_ignored = (st_q != ST_IDLE) && start_i;
  assign half_done     = (st_q == ST_WAIT) && siso_done_i;
  assign last_pass     = half_q && (iter_q == lim_q - IW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      half_q <= 1'b0;
      iter_q <= '0;
      lim_q  <= IW'(1);
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          lim_q  <= IW'(clamp_limit(int'(iter_limit_i), MAX_ITER));
          iter_q <= '0;
          half_q <= 1'b0;
          st_q   <= ST_LAUNCH;
        end
        ST_LAUNCH: st_q <= ST_WAIT;
        ST_WAIT: if (siso_done_i) begin
          if (last_pass) begin
            st_q <= ST_FIN;
          end else begin
            if (half_q) iter_q <= iter_q + IW'(1);
            half_q <= ~half_q;
            st_q   <= ST_LAUNCH;
          end
        end
        ST_FIN: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_FIN);
  assign siso_start_o = (st_q == ST_LAUNCH);
  assign active_o     = (st_q == ST_WAIT);
  assign half_o       = half_q;
  assign final_o      = busy_o && last_pass;
  assign first_pass_o = !half_q && (iter_q == '0);

  // R2: launch is a single-cycle pulse
  a_r2_launch_single: assert property (@(posedge clk) disable iff (!rst_n)
    siso_start_o |=> !siso_start_o);
  // R2: every launch is caused by an accepted start or a finished pass
  a_r2_launch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(siso_start_o) |-> $past(start_accept) || $past(half_done));
  // R4: pass order alternates after every non-final pass
  a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (half_done && !last_pass) |=> (half_o != $past(half_o)));
  // R6: completion follows the end of the last natural pass
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(half_done && last_pass && half_o));
  // R7: a start while busy leaves the programmed limit alone
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start_ignored |=> $stable(lim_q));
endmodule

// File: rtl/itsched_addr.sv
module itsched_addr #(
  parameter int N_SYM = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          launch_i,
  input  logic          active_i,
  input  logic          half_i,
  input  logic          perm_we_i,
  input  logic [AW-1:0] perm_waddr_i,
  input  logic [AW-1:0] perm_wdata_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  output logic          rd_fire_o,
  output logic          wr_fire_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] wr_addr_o
);
  import itsched_pkg::*;

  logic [AW-1:0] perm_q [N_SYM];
  logic [AW-1:0] rcnt_q, wcnt_q;
  logic          perm_fire;

  assign perm_fire = perm_we_i && !busy_i;
  assign rd_fire_o = active_i && rd_en_i;
  assign wr_fire_o = active_i && wr_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SYM; i++) perm_q[i] <= AW'(i);
    end else if (perm_fire && (int'(perm_waddr_i) < N_SYM)) begin
      perm_q[perm_waddr_i] <= perm_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
      wcnt_q <= '0;
    end else if (launch_i) begin
      rcnt_q <= '0;
      wcnt_q <= '0;
    end else begin
      if (rd_fire_o) rcnt_q <= AW'(next_idx(int'(rcnt_q), N_SYM));
      if (wr_fire_o) wcnt_q <= AW'(next_idx(int'(wcnt_q), N_SYM));
    end
  end

  assign rd_addr_o = AW'(map_addr(int'(rcnt_q), int'(perm_q[rcnt_q]), half_i));
  assign wr_addr_o = AW'(map_addr(int'(wcnt_q), int'(perm_q[wcnt_q]), half_i));

  // R3: indices stay inside the block
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rcnt_q) < N_SYM) && (int'(wcnt_q) < N_SYM));
  // R3: each launch restarts both indices
  a_r3_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |=> (rcnt_q == '0) && (wcnt_q == '0));
  // R9: indices move only on accepted requests
  a_r9_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && !launch_i) |=> $stable(rcnt_q) && $stable(wcnt_q));
endmodule

// File: rtl/itsched_extmem.sv
module itsched_extmem #(
  parameter int N_SYM = 16,
  parameter int AW    = 4,
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic             zero_rd_i,
  input  logic             wr_fire_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [EXT_W-1:0] wdata_i,
  output logic [EXT_W-1:0] rdata_o
);
  logic [EXT_W-1:0] mem_q [N_SYM];
  logic [EXT_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SYM; i++) mem_q[i] <= '0;
    end else if (wr_fire_i && (int'(wr_addr_i) < N_SYM)) begin
      mem_q[wr_addr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_fire_i) rdata_q <= zero_rd_i ? '0 : mem_q[rd_addr_i];
  end

  assign rdata_o = rdata_q;

  // R5: first pass sees zero extrinsics
  a_r5_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire_i && zero_rd_i) |=> (rdata_o == '0));
  // R5: read data holds without a read
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire_i |=> $stable(rdata_o));
endmodule

// File: rtl/turbo_iter_sched.sv
module turbo_iter_sched #(
  parameter int N_SYM    = 16,
  parameter int EXT_W    = 8,
  parameter int MAX_ITER = 8,
  localparam int AW      = $clog2(N_SYM),
  localparam int IW      = $clog2(MAX_ITER + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             perm_we_i,
  input  logic [AW-1:0]    perm_waddr_i,
  input  logic [AW-1:0]    perm_wdata_i,
  input  logic             start_i,
  input  logic [IW-1:0]    iter_limit_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             siso_start_o,
  input  logic             siso_done_i,
  output logic             siso_half_o,
  output logic             siso_final_o,
  input  logic             ext_rd_en_i,
  output logic [AW-1:0]    ext_rd_addr_o,
  output logic [EXT_W-1:0] ext_rdata_o,
  input  logic             ext_wr_en_i,
  input  logic [EXT_W-1:0] ext_wdata_i,
  output logic [AW-1:0]    ext_wr_addr_o
);
  logic active, first_pass, rd_fire, wr_fire;

  itsched_ctrl #(.MAX_ITER(MAX_ITER), .IW(IW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .iter_limit_i(iter_limit_i),
    .siso_done_i(siso_done_i), .busy_o(busy_o), .done_o(done_o),
    .siso_start_o(siso_start_o), .half_o(siso_half_o), .final_o(siso_final_o),
    .active_o(active), .first_pass_o(first_pass)
  );

  itsched_addr #(.N_SYM(N_SYM), .AW(AW)) addr_i (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_o), .launch_i(siso_start_o),
    .active_i(active), .half_i(siso_half_o), .perm_we_i(perm_we_i),
    .perm_waddr_i(perm_waddr_i), .perm_wdata_i(perm_wdata_i),
    .rd_en_i(ext_rd_en_i), .wr_en_i(ext_wr_en_i),
    .rd_fire_o(rd_fire), .wr_fire_o(wr_fire),
    .rd_addr_o(ext_rd_addr_o), .wr_addr_o(ext_wr_addr_o)
  );

  itsched_extmem #(.N_SYM(N_SYM), .AW(AW), .EXT_W(EXT_W)) mem_i (
    .clk(clk), .rst_n(rst_n), .rd_fire_i(rd_fire), .rd_addr_i(ext_rd_addr_o),
    .zero_rd_i(first_pass), .wr_fire_i(wr_fire), .wr_addr_i(ext_wr_addr_o),
    .wdata_i(ext_wdata_i), .rdata_o(ext_rdata_o)
  );

  // R7: busy spans the decode and ends with the completion pulse
  a_r7_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));
  // R6: the final flag only appears on natural passes
  a_r6_final_natural: assert property (@(posedge clk) disable iff (!rst_n)
    siso_final_o |-> siso_half_o);
endmodule

// File: tb/turbo_iter_sched_tb.sv
module turbo_iter_sched_tb_top;
  localparam int N = 16, EW = 8, MI = 8, AW = 4, IW = 4;

  logic clk = 0, rst_n = 0;
  logic perm_we = 0, start = 0, sdone = 0, rd_en = 0, wr_en = 0;
  logic [AW-1:0] perm_waddr = 0, perm_wdata = 0;
  logic [IW-1:0] lim = 0;
  logic [EW-1:0] wdata = 0;
  logic busy, done, sstart, half, fin;
  logic [AW-1:0] raddr, waddr;
  logic [EW-1:0] rdata;

  always #5 clk = ~clk;

  turbo_iter_sched dut_i (
    .clk(clk), .rst_n(rst_n), .perm_we_i(perm_we), .perm_waddr_i(perm_waddr),
    .perm_wdata_i(perm_wdata), .start_i(start), .iter_limit_i(lim),
    .busy_o(busy), .done_o(done), .siso_start_o(sstart), .siso_done_i(sdone),
    .siso_half_o(half), .siso_final_o(fin), .ext_rd_en_i(rd_en),
    .ext_rd_addr_o(raddr), .ext_rdata_o(rdata), .ext_wr_en_i(wr_en),
    .ext_wdata_i(wdata), .ext_wr_addr_o(waddr)
  );

  int vectors = 0, fails = 0, cyc = 0;

  // ---------------- behavioural reference ----------------
  int m_st = 0, m_half = 0, m_iter = 0, m_lim = 1, m_rc = 0, m_wc = 0, m_rdata = 0;
  int m_perm[N];
  int m_mem[N];

  function automatic int mapped(int k);
    return (m_half == 1) ? k : m_perm[k];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_half = 0; m_iter = 0; m_lim = 1; m_rc = 0; m_wc = 0; m_rdata = 0;
      for (int i = 0; i < N; i++) begin m_perm[i] = i; m_mem[i] = 0; end
    end else begin
      if (perm_we && m_st == 0) m_perm[perm_waddr] = perm_wdata;
      if (m_st == 2) begin
        if (rd_en) begin
          m_rdata = (m_iter == 0 && m_half == 0) ? 0 : m_mem[mapped(m_rc)];
          m_rc = (m_rc + 1) % N;
        end
        if (wr_en) begin
          m_mem[mapped(m_wc)] = wdata;
          m_wc = (m_wc + 1) % N;
        end
      end
      case (m_st)
        0: if (start) begin
             m_lim = (lim < 1) ? 1 : (lim > MI) ? MI : int'(lim);
             m_iter = 0; m_half = 0; m_st = 1;
           end
        1: begin m_rc = 0; m_wc = 0; m_st = 2; end
        2: if (sdone) begin
             if (m_half == 1 && m_iter == m_lim - 1) m_st = 3;
             else begin
               if (m_half == 1) m_iter++;
               m_half = 1 - m_half; m_st = 1;
             end
           end
        default: m_st = 0;
      endcase
    end
  end

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp("R7 busy_o", busy, m_st != 0);
    cmp("R6 done_o", done, m_st == 3);
    cmp("R2 siso_start_o", sstart, m_st == 1);
    cmp("R4 siso_half_o", half, m_half);
    cmp("R6 siso_final_o", fin, (m_st != 0) && m_half == 1 && m_iter == m_lim - 1);
    cmp("R5 ext_rdata_o", rdata, m_rdata);
    cmp("R3 ext_rd_addr_o", raddr, mapped(m_rc));
    cmp("R3 ext_wr_addr_o", waddr, mapped(m_wc));
  end

  // watchdog
  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // One decode with an emulated engine. dense=1: read+write every cycle.
  // inject=1: start and table write while busy (R7, R8); stray=1: requests
  // and a completion during launch cycles (R9, R2).
  task automatic run_decode(int lim_req, int exp_passes, int dense, int lat,
                            int inject, int stray, int seed);
    int passes = 0;
    bit finished = 0;
    lim = IW'(lim_req); start = 1; step(); start = 0;
    while (!finished && cyc < 140000) begin
      if (!sstart) begin cmp("R2 launch expected", sstart, 1); break; end
      passes++;
      if (stray) begin rd_en = 1; wr_en = 1; sdone = 1; wdata = 8'hEE; end
      step();                                     // now waiting on engine
      rd_en = 0; wr_en = 0; sdone = 0;
      for (int i = 0; i < N; i++) begin
        rd_en = 1; wr_en = 1; wdata = EW'(seed + passes * 13 + i * 7);
        if (inject && passes == 2 && i == 3) begin
          start = 1; lim = IW'(1); perm_we = 1; perm_waddr = 0; perm_wdata = 4'd9;
        end
        step();
        start = 0; perm_we = 0;
        if (!dense) begin rd_en = 0; wr_en = 0; step(); end
      end
      rd_en = 0; wr_en = 0;
      for (int j = 0; j < lat; j++) step();
      sdone = 1; step(); sdone = 0;
      if (done) finished = 1;
    end
    cmp("R4 pass count", passes, exp_passes);
    cmp("R6 done observed", finished, 1);
    step();
    cmp("R7 idle after done", busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp("R1 busy after reset", busy, 0);
    cmp("R1 done after reset", done, 0);
    cmp("R1 start after reset", sstart, 0);
    cmp("R1 rdata after reset", rdata, 0);
    cmp("R1 half after reset", half, 0);
    rst_n = 1;
    step();
    // R8: load permutation (5k+3) mod 16 while idle
    for (int k = 0; k < N; k++) begin
      perm_we = 1; perm_waddr = AW'(k); perm_wdata = AW'((5 * k + 3) % N); step();
    end
    perm_we = 0; step();
    run_decode(2, 4, 1, 0, 0, 0, 11);    // R4, R5 dense
    run_decode(0, 2, 0, 7, 0, 1, 40);    // R4 clamp low, R2 latency, R9
    run_decode(3, 6, 1, 2, 1, 0, 77);    // R7, R8 mid-run injection
    run_decode(12, 16, 0, 1, 0, 1, 5);   // R4 clamp high
    run_decode(1, 2, 1, 30, 0, 0, 90);   // R2 long engine latency
    step(); step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule